// File: doc/BRIEF.md
# Entropy Sampling Register Controller

This block sits between a raw noise input and a 32-bit register bus. Software programs a sample period, issues a start command, and the controller captures one noise bit per period until 128 bits have been gathered into four 32-bit result words. A valid flag then stays up until software acknowledges it. The acknowledge also wipes the result words, so a consumed result can never be read a second time.

The sequencer has three named states. **ST_IDLE** waits for a start command. The **start** transition (ST_IDLE to ST_SAMPLE) latches the sample period. **ST_SAMPLE** paces captures with a period timer and shifts each captured bit into the result. The **fill** transition (ST_SAMPLE to ST_DONE) fires on the edge that captures the 128th bit. The **abort** transition (ST_SAMPLE to ST_IDLE) discards a partial result. **ST_DONE** holds the result and raises the valid flag. The **acknowledge** transition goes from any state to ST_IDLE and clears every result word.

An interrupt output follows the valid flag whenever interrupt mask bit 0 is set. With the mask at zero, software polls the status register instead.

Top module: `entropy_reg_ctrl`

## Requirements
- R1: After reset the four result words and the status register read 0, the configuration register reads 1, the mask register reads 0 and irq_out is 0.
- R2: A write of value v to the configuration register (offset 24) stores 1 if v is 0, stores 231 if v is above 231, and otherwise stores v. The stored value reads back at offset 24.
- R3: Writing 32'd1 to the control register (offset 20) in ST_IDLE starts sampling with P equal to the stored configuration value. The first bit of noise_in is captured on the P-th clock edge after the command edge, and a further bit every P edges after that. Status bit 0 rises on the edge of the 128th capture and not before.
- R4: The 128-bit result shifts left with each new bit entering at bit 0. The word at offset 0 holds the last 32 bits captured, with the final bit in its bit 0. The word at offset 12 holds the first 32 bits captured, with the first bit in its bit 31.
- R5: The status register (offset 16) reads {31'b0, valid}. The mask register (offset 28) reads back its bit 0. irq_out equals valid AND mask bit 0.
- R6: A write with bit 0 set to the status register clears all result words, drops valid, ends any sampling and returns to ST_IDLE. A status write with bit 0 clear has no effect.
- R7: A start command issued while valid is 1 is ignored: valid stays 1 and the result words are unchanged.
- R8: Writing 32'd2 to the control register in ST_SAMPLE abandons the cycle: the result words read 0 and valid never rises for that cycle.
- R9: An abort while valid is 1, and any control code other than 1 or 2 (for example 3), has no effect.
- R10: A start command issued during ST_SAMPLE is ignored. Capture timing continues from the original start.
- R11: A configuration write during ST_SAMPLE does not change the period of the cycle in progress. The new value reads back at once.
- R12: The control register reads 0. Accesses with bus_addr[1:0] not equal to 0 are ignored and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe for the current cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data, combinational from bus_addr |
| noise_in | input | 1 | Raw noise bit from the physical source |
| irq_out | output | 1 | Result-ready interrupt, gated by mask bit 0 |

## Verification
The bench sweeps the period over 1, 2, 3, 7 and 231, plus the saturation inputs 0, 232 and all-ones. For every period it checks that valid rises on exactly the predicted edge: an off-by-one in the period timer makes valid rise one edge early or late, and a wrong bit order scrambles the predicted words. The bench drives the noise as a known function of the cycle number, so every result bit is predicted arithmetically. It then hits the command corner cases: start while valid (a faulty design restarts and drops valid), abort while valid (a faulty design clears the result), start during sampling (a faulty design restarts and delays valid), and a configuration change mid-cycle (a design without the period latch shifts capture timing). It also checks that an abort clears the partial result and that unaligned or bit0-clear status writes are ignored.

// File: rtl/entropy_pkg.sv
package entropy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DONE   = 2'd2
    } es_state_t;

    localparam logic [31:0] CMD_START = 32'd1;
    localparam logic [31:0] CMD_ABORT = 32'd2;

    localparam int REG_STATUS = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_CFG    = 2;
    localparam int REG_MASK   = 3;
    localparam int NUM_CTRL_REGS = 4;

endpackage

// File: rtl/es_pace_timer.sv
module es_pace_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] period_in,
    input  logic          run,
    output logic          tick
);

    logic [CW-1:0] period_q;
    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == period_q - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= CW'(1);
        end else if (load) begin
            period_q <= period_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < period_q)); // R3
    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_q != '0); // R2

endmodule

// File: rtl/es_bit_collector.sv
module es_bit_collector #(
    parameter int NBITS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [NBITS-1:0] bits_q,
    output logic             last_bit
);

    localparam int CW = $clog2(NBITS);

    logic [CW-1:0] cnt_q;

    assign last_bit = shift_en && (cnt_q == CW'(NBITS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            bits_q <= {bits_q[NBITS-2:0], bit_in};
            cnt_q  <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bits_q == '0)); // R6
    AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift_en) |=> $stable(bits_q)); // R7

endmodule

// File: rtl/es_sequencer.sv
module es_sequencer
    import entropy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_cmd,
    input  logic      abort_cmd,
    input  logic      ack_cmd,
    input  logic      last_bit,
    output es_state_t state_q,
    output logic      run_o,
    output logic      load_o,
    output logic      clear_o,
    output logic      valid_o
);

    es_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ack_cmd && start_cmd) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (ack_cmd || abort_cmd) state_d = ST_IDLE;
                else if (last_bit)        state_d = ST_DONE;
            end
            ST_DONE: begin
                if (ack_cmd) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o   = 1'b0;
        load_o  = 1'b0;
        valid_o = 1'b0;
        clear_o = ack_cmd;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_cmd && !ack_cmd;
            end
            ST_SAMPLE: begin
                run_o   = 1'b1;
                clear_o = ack_cmd || abort_cmd;
            end
            ST_DONE: begin
                valid_o = 1'b1;
            end
            default: ;
        endcase
    end

    AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(state_q) == ST_SAMPLE)); // R3
    AST_START_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && start_cmd && !ack_cmd) |=> valid_o); // R7
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && abort_cmd) |=> (state_q == ST_IDLE)); // R8
    AST_ABORT_KEEPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && abort_cmd && !ack_cmd) |=> valid_o); // R9
    AST_ACK_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cmd |=> !valid_o); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && start_cmd) |-> !load_o); // R10

endmodule

// File: rtl/entropy_reg_ctrl.sv
module entropy_reg_ctrl
    import entropy_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int CFG_MAX   = 231,
    parameter int ADDR_W    = $clog2(NUM_WORDS + NUM_CTRL_REGS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    output logic [DATA_W-1:0] bus_rd_data,
    input  logic              noise_in,
    output logic              irq_out
);

    localparam int NBITS = DATA_W * NUM_WORDS;
    localparam int CFG_W = $clog2(CFG_MAX + 1);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic              wr_ok;
    logic              wr_status;
    logic              wr_ctrl;
    logic              wr_cfg;
    logic              wr_mask;
    logic              start_cmd;
    logic              abort_cmd;
    logic              ack_cmd;
    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  cfg_sat;
    logic              mask_q;
    es_state_t         state;
    logic              run;
    logic              load;
    logic              clear;
    logic              valid;
    logic              tick;
    logic              last_bit;
    logic [NBITS-1:0]  bits;
    logic [DATA_W-1:0] words [NUM_WORDS];

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr_en && aligned;

    assign wr_status = wr_ok && (idx == IDX_W'(NUM_WORDS + REG_STATUS));
    assign wr_ctrl   = wr_ok && (idx == IDX_W'(NUM_WORDS + REG_CTRL));
    assign wr_cfg    = wr_ok && (idx == IDX_W'(NUM_WORDS + REG_CFG));
    assign wr_mask   = wr_ok && (idx == IDX_W'(NUM_WORDS + REG_MASK));

    assign start_cmd = wr_ctrl && (bus_wr_data == CMD_START);
    assign abort_cmd = wr_ctrl && (bus_wr_data == CMD_ABORT);
    assign ack_cmd   = wr_status && bus_wr_data[0];

    always_comb begin
        if (bus_wr_data == '0) begin
            cfg_sat = CFG_W'(1);
        end else if (bus_wr_data > DATA_W'(CFG_MAX)) begin
            cfg_sat = CFG_W'(CFG_MAX);
        end else begin
            cfg_sat = bus_wr_data[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_W'(1);
            mask_q <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= cfg_sat;
            if (wr_mask) mask_q <= bus_wr_data[0];
        end
    end

    es_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .abort_cmd (abort_cmd),
        .ack_cmd   (ack_cmd),
        .last_bit  (last_bit),
        .state_q   (state),
        .run_o     (run),
        .load_o    (load),
        .clear_o   (clear),
        .valid_o   (valid)
    );

    es_pace_timer #(.CW(CFG_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .period_in (cfg_q),
        .run       (run),
        .tick      (tick)
    );

    es_bit_collector #(.NBITS(NBITS)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (tick),
        .bit_in   (noise_in),
        .bits_q   (bits),
        .last_bit (last_bit)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign words[w] = bits[w*DATA_W +: DATA_W];
    end

    always_comb begin
        bus_rd_data = '0;
        if (aligned) begin
            if (idx < IDX_W'(NUM_WORDS)) begin
                bus_rd_data = words[idx[$clog2(NUM_WORDS)-1:0]];
            end else if (idx == IDX_W'(NUM_WORDS + REG_STATUS)) begin
                bus_rd_data = DATA_W'(valid);
            end else if (idx == IDX_W'(NUM_WORDS + REG_CFG)) begin
                bus_rd_data = DATA_W'(cfg_q);
            end else if (idx == IDX_W'(NUM_WORDS + REG_MASK)) begin
                bus_rd_data = DATA_W'(mask_q);
            end
        end
    end

    assign irq_out = valid && mask_q;

    AST_CFG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q >= CFG_W'(1)) && (cfg_q <= CFG_W'(CFG_MAX))); // R2
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq_out); // R5
    AST_SAMPLE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |-> !irq_out); // R5

endmodule

// File: tb/entropy_reg_ctrl_tb_top.sv
module entropy_reg_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 128;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        noise_in = 1'b0;
    logic        irq_out;

    int          cyc = 0;
    int          nchk = 0;
    int          nfail = 0;
    int          wr_cyc = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    entropy_reg_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .noise_in    (noise_in),
        .irq_out     (irq_out)
    );

    function automatic logic pat(int m);
        logic [31:0] h;
        h = (32'(m) * 32'h9E37_79B1) ^ seed;
        return ^h[31:19];
    endfunction

    function automatic logic [NBITS-1:0] expect_bits(int s, int p);
        logic [NBITS-1:0] v;
        for (int k = 0; k < NBITS; k++) v[NBITS-1-k] = pat(s + 1 + (k + 1) * p);
        return v;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) noise_in <= pat(cyc + 1);

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            nfail++;
            $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr_cyc      = cyc;
        bus_addr    = a;
        bus_wr_data = d;
        bus_wr_en   = 1'b1;
        @(negedge clk);
        bus_wr_en   = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rd_data;
    endtask

    task automatic read_check(string req, logic [4:0] a, logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid(string req, int s, int p);
        int e;
        e = s + 1 + NBITS * p;
        while (cyc < e - 1) @(negedge clk);
        read_check({req, " status before fill"}, 5'd16, 32'd0);
        @(negedge clk);
        read_check({req, " status at fill"}, 5'd16, 32'd1);
    endtask

    task automatic check_words(string req, logic [NBITS-1:0] v);
        for (int w = 0; w < 4; w++) read_check(req, 5'(w * 4), v[w*32 +: 32]);
    endtask

    initial begin
        int plist [5] = '{1, 2, 3, 7, 231};
        int s0;
        logic [NBITS-1:0] ev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < 4; w++) read_check("R1 word", 5'(w * 4), 32'd0);
        read_check("R1 status", 5'd16, 32'd0);
        read_check("R1 config", 5'd24, 32'd1);
        read_check("R1 mask", 5'd28, 32'd0);
        check("R1 irq", 32'(irq_out), 32'd0);
        // R12 control reads zero
        read_check("R12 control read", 5'd20, 32'd0);

        // R2 saturation sweep
        bus_write(5'd24, 32'd0);         read_check("R2 cfg 0", 5'd24, 32'd1);
        bus_write(5'd24, 32'd232);       read_check("R2 cfg 232", 5'd24, 32'd231);
        bus_write(5'd24, 32'hFFFF_FFFF); read_check("R2 cfg max", 5'd24, 32'd231);
        bus_write(5'd24, 32'd231);       read_check("R2 cfg 231", 5'd24, 32'd231);
        bus_write(5'd24, 32'd1);         read_check("R2 cfg 1", 5'd24, 32'd1);
        // R12 unaligned write ignored
        bus_write(5'd25, 32'd9);         read_check("R12 unaligned cfg write", 5'd24, 32'd1);

        foreach (plist[i]) begin
            int p;
            logic msk;
            p   = plist[i];
            msk = logic'(i % 2);
            seed = 32'hA5A5_0000 + 32'(i * 977);
            bus_write(5'd24, 32'(p));
            bus_write(5'd28, 32'(msk));
            read_check("R5 mask readback", 5'd28, 32'(msk));
            bus_write(5'd20, 32'd1);
            s0 = wr_cyc;
            check("R5 irq low while sampling", 32'(irq_out), 32'd0);
            wait_valid("R3", s0, p);
            ev = expect_bits(s0, p);
            check_words("R4 words", ev);
            check("R5 irq", 32'(irq_out), 32'(msk));

            // R7 start while valid ignored
            bus_write(5'd20, 32'd1);
            idle(3);
            read_check("R7 status kept", 5'd16, 32'd1);
            check_words("R7 words kept", ev);
            // R9 abort and other code while valid ignored
            bus_write(5'd20, 32'd2);
            bus_write(5'd20, 32'd3);
            idle(2);
            read_check("R9 status kept", 5'd16, 32'd1);
            check_words("R9 words kept", ev);
            // R6 status write with bit0 clear, R12 unaligned status write
            bus_write(5'd16, 32'd2);
            bus_write(5'd17, 32'd1);
            read_check("R6 bit0-clear ack ignored", 5'd16, 32'd1);
            read_check("R12 unaligned read", 5'd1, 32'd0);
            // R6 acknowledge
            bus_write(5'd16, 32'd1);
            read_check("R6 status cleared", 5'd16, 32'd0);
            check_words("R6 words cleared", '0);
            check("R6 irq cleared", 32'(irq_out), 32'd0);
        end

        // R8 abort during sampling
        seed = 32'h0BAD_F00D;
        bus_write(5'd24, 32'd2);
        bus_write(5'd20, 32'd1);
        idle(40);
        bus_write(5'd20, 32'd2);
        check_words("R8 partial cleared", '0);
        idle(NBITS * 2 + 20);
        read_check("R8 no valid", 5'd16, 32'd0);
        check_words("R8 words stay zero", '0);

        // R10 start during sampling ignored
        seed = 32'h7777_1111;
        bus_write(5'd20, 32'd1);
        s0 = wr_cyc;
        idle(21);
        bus_write(5'd20, 32'd1);
        wait_valid("R10", s0, 2);
        check_words("R10 words", expect_bits(s0, 2));
        bus_write(5'd16, 32'd1);

        // R11 config write mid-cycle
        seed = 32'h3C3C_9999;
        bus_write(5'd24, 32'd3);
        bus_write(5'd20, 32'd1);
        s0 = wr_cyc;
        idle(10);
        bus_write(5'd24, 32'd5);
        read_check("R11 cfg readback", 5'd24, 32'd5);
        wait_valid("R11", s0, 3);
        check_words("R11 words", expect_bits(s0, 3));
        bus_write(5'd16, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule